// File: doc/BRIEF.md
# Tamper Response and Event Logger

This block sits in the battery-backed part of a security monitor. It gathers event pulses from the environmental sensors and from six external tamper loops into one sticky alarm word. Software clears each flag by writing 1 to it. The same alarm word also holds two action triggers. One starts a destructive reset and the other starts a key erase. A sequencer orders the two actions and records the real-time-clock seconds value at every destructive reset.

The block also holds a lockable word of internal sensor enables, with a low-temperature threshold select. It keeps two diagnostic flags: one that marks the first clock after backup power is applied, and one that marks a completed key transfer. The only reset is the battery reset, so everything here keeps its value until backup power is lost.

Top module: `tamper_logger`

## Requirements
- R1: While `bat_rst` is high, `alarm_o`, `diag_o`, `log_o`, `drs_req_o`, `wipe_req_o` and the enable word with its lock and select bits are all zero. On the first clock edge after release, diagnostic bit 0 (power-applied flag) becomes 1.
- R2: The internal event inputs `int_evt_i[0..9]` (shield, low temp, high temp, battery low, battery high, VDD low, VCORE low, VCORE high, VDD high, glitch) set alarm bits 2, 3, 4, 5, 6, 8, 9, 10, 11, 12 respectively. A bit is set one clock after an event only if the matching bit of the enable word is 1.
- R3: Writing 1 to a flag bit through `alm_we`/`alm_wdata` clears it. If the event is still active in the same cycle, the clear is ignored. Writing 0 leaves the flag unchanged.
- R4: External detect `ext_det_i[k]` sets alarm bit 16+k only while `ext_en_i[k]` is 1. Alarm bit 7 always equals the OR of alarm bits 16 to 21.
- R5: Writing 1 to alarm bit 0, with no key erase running or starting, sets bit 0 for one cycle. A single-cycle `drs_req_o` pulse follows on the next clock, and bit 0 clears on that same clock.
- R6: `log_o` changes only on the clock that raises `drs_req_o`. On that clock it takes the value of `rtc_sec_i`.
- R7: Writing 1 to alarm bit 1 drives `wipe_req_o` high for exactly WIPE_CYCLES (4) clocks, and bit 1 reads 1 for that time. The erase raises no reset request and leaves `log_o` unchanged.
- R8: When bits 0 and 1 are written in the same write, the full erase runs first. `drs_req_o` rises one clock after `wipe_req_o` falls, and the two are never high together.
- R9: A `cfg_we` write loads the enable word, the low-temperature select and the lock bit. Once the lock bit is 1, further `cfg_we` writes are ignored until `bat_rst`.
- R10: A `key_xfer_i` pulse sets diagnostic bit 8, which only `bat_rst` clears. Writing 1 to diagnostic bit 0 through `diag_we` clears the power-applied flag. A diagnostic write has no effect on bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| bat_rst | input | 1 | Battery reset, active high, asynchronous |
| int_evt_i | input | 10 | Internal sensor event pulses |
| ext_det_i | input | NUM_EXT | External tamper detect pulses |
| ext_en_i | input | NUM_EXT | External sensor enables |
| rtc_sec_i | input | 32 | Real-time-clock seconds value |
| key_xfer_i | input | 1 | Key transfer done pulse |
| alm_we | input | 1 | Alarm word write strobe |
| alm_wdata | input | 32 | Alarm write data (triggers, write-1-to-clear flags) |
| diag_we | input | 1 | Diagnostic word write strobe |
| diag_wdata | input | 32 | Diagnostic write data (bit 0 write-1-to-clear) |
| cfg_we | input | 1 | Enable word write strobe |
| cfg_en_i | input | 10 | New internal enable bits |
| cfg_lotemp_i | input | 1 | New low-temperature threshold select |
| cfg_lock_i | input | 1 | New lock bit |
| alarm_o | output | 32 | Alarm word |
| diag_o | output | 32 | Diagnostic word |
| log_o | output | 32 | Seconds value at last destructive reset |
| drs_req_o | output | 1 | Destructive reset request pulse |
| wipe_req_o | output | 1 | Key erase request |
| int_en_o | output | 10 | Internal enable word |
| lotemp_sel_o | output | 1 | Low-temperature threshold select |
| int_lock_o | output | 1 | Enable word lock |

## Verification
The assertions check several rules on every clock. The reset request is a one-cycle pulse and never overlaps the erase request. The log moves only with a reset pulse. An external flag never rises while its enable was low. A locked enable word never changes, and the key-transfer flag never drops. Other behaviour needs the bench's scenarios. These cover the exact cycle counts of the erase and of the reset that follows it, the captured seconds value, and a clear that loses against a live event. They also cover the bit positions of each internal source under random event, enable and clear traffic.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
    localparam int REG_W        = 32;
    localparam int NUM_INT      = 10;
    localparam int DRS_BIT      = 0;
    localparam int WIPE_BIT     = 1;
    localparam int EXT_SUM_BIT  = 7;
    localparam int DIAG_BOR_BIT = 0;
    localparam int DIAG_KEY_BIT = 8;

    // internal sources 0..4 sit at bits 2..6, sources 5..9 at bits 8..12
    function automatic int int_bit_pos(input int k);
        return (k < 5) ? k + 2 : k + 3;
    endfunction
endpackage

// File: rtl/tl_flag_bank.sv
module tl_flag_bank #(
    parameter int NI = 10,
    parameter int NE = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NI-1:0] int_evt_i,
    input  logic [NI-1:0] int_en_i,
    input  logic [NI-1:0] clr_int_i,
    input  logic [NE-1:0] ext_det_i,
    input  logic [NE-1:0] ext_en_i,
    input  logic [NE-1:0] clr_ext_i,
    output logic [NI-1:0] int_flags_o,
    output logic [NE-1:0] ext_flags_o
);
    typedef struct packed {
        logic [NI-1:0] intf;
        logic [NE-1:0] extf;
    } flag_t;

    flag_t s_d, s_q;

    // set has priority over a clear in the same cycle
    always_comb begin
        s_d.intf = (s_q.intf & ~clr_int_i) | (int_evt_i & int_en_i);
        s_d.extf = (s_q.extf & ~clr_ext_i) | (ext_det_i & ext_en_i);
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign int_flags_o = s_q.intf;
    assign ext_flags_o = s_q.extf;
endmodule

// File: rtl/tl_action_seq.sv
module tl_action_seq #(
    parameter int WIPE_CYCLES = 4,
    parameter int TS_W        = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_drs_i,
    input  logic            start_wipe_i,
    input  logic [TS_W-1:0] rtc_i,
    output logic            drs_pend_o,
    output logic            drs_req_o,
    output logic            wipe_req_o,
    output logic [TS_W-1:0] log_o
);
    localparam int CNT_W = $clog2(WIPE_CYCLES + 1);

    typedef struct packed {
        logic             pend;
        logic [CNT_W-1:0] cnt;
        logic             req;
        logic [TS_W-1:0]  stamp;
    } seq_t;

    seq_t s_d, s_q;
    logic wipe_idle, wipe_go, fire;

    always_comb begin
        wipe_idle = (s_q.cnt == '0);
        wipe_go   = start_wipe_i && wipe_idle;
        // a reset waits for any erase that is running or starting
        fire      = s_q.pend && wipe_idle && !start_wipe_i;

        s_d       = s_q;
        s_d.req   = fire;
        s_d.pend  = start_drs_i | (s_q.pend & ~fire);
        if (wipe_go)
            s_d.cnt = CNT_W'(WIPE_CYCLES);
        else if (!wipe_idle)
            s_d.cnt = s_q.cnt - 1'b1;
        if (fire)
            s_d.stamp = rtc_i;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign drs_pend_o = s_q.pend;
    assign drs_req_o  = s_q.req;
    assign wipe_req_o = (s_q.cnt != '0);
    assign log_o      = s_q.stamp;
endmodule

// File: rtl/tamper_logger.sv
module tamper_logger
    import tamper_pkg::*;
#(
    parameter int NUM_EXT     = 6,
    parameter int EXT_LSB     = 16,
    parameter int WIPE_CYCLES = 4
) (
    input  logic               clk,
    input  logic               bat_rst,
    input  logic [NUM_INT-1:0] int_evt_i,
    input  logic [NUM_EXT-1:0] ext_det_i,
    input  logic [NUM_EXT-1:0] ext_en_i,
    input  logic [REG_W-1:0]   rtc_sec_i,
    input  logic               key_xfer_i,
    input  logic               alm_we,
    input  logic [REG_W-1:0]   alm_wdata,
    input  logic               diag_we,
    input  logic [REG_W-1:0]   diag_wdata,
    input  logic               cfg_we,
    input  logic [NUM_INT-1:0] cfg_en_i,
    input  logic               cfg_lotemp_i,
    input  logic               cfg_lock_i,
    output logic [REG_W-1:0]   alarm_o,
    output logic [REG_W-1:0]   diag_o,
    output logic [REG_W-1:0]   log_o,
    output logic               drs_req_o,
    output logic               wipe_req_o,
    output logic [NUM_INT-1:0] int_en_o,
    output logic               lotemp_sel_o,
    output logic               int_lock_o
);
    typedef struct packed {
        logic [NUM_INT-1:0] en;
        logic               lotemp;
        logic               lock;
        logic               seen;
        logic               bor;
        logic               key;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [NUM_INT-1:0] clr_int, int_flags;
    logic [NUM_EXT-1:0] clr_ext, ext_flags;
    logic               drs_pend, start_drs, start_wipe;
    logic               unused_bits;

    genvar k;
    generate
        for (k = 0; k < NUM_INT; k++) begin : g_clr
            assign clr_int[k] = alm_we & alm_wdata[int_bit_pos(k)];
        end
    endgenerate

    assign clr_ext     = {NUM_EXT{alm_we}} & alm_wdata[EXT_LSB +: NUM_EXT];
    assign start_drs   = alm_we & alm_wdata[DRS_BIT];
    assign start_wipe  = alm_we & alm_wdata[WIPE_BIT];
    assign unused_bits = ^alm_wdata ^ ^diag_wdata;

    tl_flag_bank #(.NI(NUM_INT), .NE(NUM_EXT)) u_flags (
        .clk        (clk),
        .rst        (bat_rst),
        .int_evt_i  (int_evt_i),
        .int_en_i   (c_q.en),
        .clr_int_i  (clr_int),
        .ext_det_i  (ext_det_i),
        .ext_en_i   (ext_en_i),
        .clr_ext_i  (clr_ext),
        .int_flags_o(int_flags),
        .ext_flags_o(ext_flags)
    );

    tl_action_seq #(.WIPE_CYCLES(WIPE_CYCLES), .TS_W(REG_W)) u_seq (
        .clk         (clk),
        .rst         (bat_rst),
        .start_drs_i (start_drs),
        .start_wipe_i(start_wipe),
        .rtc_i       (rtc_sec_i),
        .drs_pend_o  (drs_pend),
        .drs_req_o   (drs_req_o),
        .wipe_req_o  (wipe_req_o),
        .log_o       (log_o)
    );

    always_comb begin
        c_d      = c_q;
        c_d.seen = 1'b1;
        if (cfg_we && !c_q.lock) begin
            c_d.en     = cfg_en_i;
            c_d.lotemp = cfg_lotemp_i;
            c_d.lock   = cfg_lock_i;
        end
        if (!c_q.seen)
            c_d.bor = 1'b1;
        else if (diag_we && diag_wdata[DIAG_BOR_BIT])
            c_d.bor = 1'b0;
        c_d.key = c_q.key | key_xfer_i;
    end

    always_ff @(posedge clk or posedge bat_rst) begin
        if (bat_rst) c_q <= '0;
        else         c_q <= c_d;
    end

    always_comb begin
        alarm_o = '0;
        for (int i = 0; i < NUM_INT; i++)
            alarm_o[int_bit_pos(i)] = int_flags[i];
        alarm_o[EXT_LSB +: NUM_EXT] = ext_flags;
        alarm_o[EXT_SUM_BIT]        = |ext_flags;
        alarm_o[DRS_BIT]            = drs_pend;
        alarm_o[WIPE_BIT]           = wipe_req_o;

        diag_o               = '0;
        diag_o[DIAG_BOR_BIT] = c_q.bor;
        diag_o[DIAG_KEY_BIT] = c_q.key;
    end

    assign int_en_o     = c_q.en;
    assign lotemp_sel_o = c_q.lotemp;
    assign int_lock_o   = c_q.lock;
endmodule

// File: rtl/tamper_logger_chk.sv
module tamper_logger_chk #(
    parameter int NUM_EXT = 6,
    parameter int EXT_LSB = 16,
    parameter int NI      = 10
) (
    input logic               clk,
    input logic               bat_rst,
    input logic [NUM_EXT-1:0] ext_en_i,
    input logic [NUM_EXT-1:0] ext_flags,
    input logic               key_flag,
    input logic [31:0]        log_o,
    input logic               drs_req_o,
    input logic               wipe_req_o,
    input logic [NI-1:0]      int_en_o,
    input logic               int_lock_o
);
    p_drs_pulse_r5: assert property (@(posedge clk) disable iff (bat_rst)
        drs_req_o |=> !drs_req_o);

    p_drs_after_wipe_r8: assert property (@(posedge clk) disable iff (bat_rst)
        drs_req_o |-> !wipe_req_o);

    p_log_on_drs_r6: assert property (@(posedge clk) disable iff (bat_rst)
        !$stable(log_o) |-> drs_req_o);

    p_ext_gated_r4: assert property (@(posedge clk) disable iff (bat_rst)
        (ext_flags & ~$past(ext_flags) & ~$past(ext_en_i)) == '0);

    p_lock_hold_r9: assert property (@(posedge clk) disable iff (bat_rst)
        int_lock_o |=> (int_lock_o && $stable(int_en_o)));

    p_key_sticky_r10: assert property (@(posedge clk) disable iff (bat_rst)
        key_flag |=> key_flag);
endmodule

bind tamper_logger tamper_logger_chk #(.NUM_EXT(NUM_EXT), .EXT_LSB(EXT_LSB), .NI(tamper_pkg::NUM_INT)) u_chk (
    .clk       (clk),
    .bat_rst   (bat_rst),
    .ext_en_i  (ext_en_i),
    .ext_flags (alarm_o[EXT_LSB +: NUM_EXT]),
    .key_flag  (diag_o[tamper_pkg::DIAG_KEY_BIT]),
    .log_o     (log_o),
    .drs_req_o (drs_req_o),
    .wipe_req_o(wipe_req_o),
    .int_en_o  (int_en_o),
    .int_lock_o(int_lock_o)
);

// File: tb/tamper_logger_test.sv
`timescale 1ns/1ps
module tamper_logger_test;
    logic        clk = 1'b0;
    logic        bat_rst;
    logic [9:0]  int_evt_i;
    logic [5:0]  ext_det_i, ext_en_i;
    logic [31:0] rtc_sec_i;
    logic        key_xfer_i, alm_we, diag_we, cfg_we, cfg_lotemp_i, cfg_lock_i;
    logic [31:0] alm_wdata, diag_wdata;
    logic [9:0]  cfg_en_i;
    logic [31:0] alarm_o, diag_o, log_o;
    logic        drs_req_o, wipe_req_o, lotemp_sel_o, int_lock_o;
    logic [9:0]  int_en_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tamper_logger uut (
        .clk(clk), .bat_rst(bat_rst), .int_evt_i(int_evt_i), .ext_det_i(ext_det_i),
        .ext_en_i(ext_en_i), .rtc_sec_i(rtc_sec_i), .key_xfer_i(key_xfer_i),
        .alm_we(alm_we), .alm_wdata(alm_wdata), .diag_we(diag_we), .diag_wdata(diag_wdata),
        .cfg_we(cfg_we), .cfg_en_i(cfg_en_i), .cfg_lotemp_i(cfg_lotemp_i), .cfg_lock_i(cfg_lock_i),
        .alarm_o(alarm_o), .diag_o(diag_o), .log_o(log_o), .drs_req_o(drs_req_o),
        .wipe_req_o(wipe_req_o), .int_en_o(int_en_o), .lotemp_sel_o(lotemp_sel_o),
        .int_lock_o(int_lock_o)
    );

    function automatic int src_pos(input int k);
        case (k)
            0: return 2;  1: return 3;  2: return 4;  3: return 5;  4: return 6;
            5: return 8;  6: return 9;  7: return 10; 8: return 11; default: return 12;
        endcase
    endfunction

    function automatic logic [31:0] exp_word(input logic [9:0] fi, input logic [5:0] fe,
                                             input logic pend, input logic busy);
        logic [31:0] w = '0;
        for (int k = 0; k < 10; k++) w[src_pos(k)] = fi[k];
        w[21:16] = fe;
        w[7]     = |fe;
        w[0]     = pend;
        w[1]     = busy;
        return w;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(4 * 50000);
        errors++;
        $display("FAIL watchdog expired (R1..R10 incomplete) actual=%h expected=%h", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        logic [9:0]  m_int, clr_i, en_cfg;
        logic [5:0]  m_ext, clr_e;
        logic [31:0] saved;
        void'($urandom(32'd4242));
        bat_rst = 1'b1; int_evt_i = '0; ext_det_i = '0; ext_en_i = '0; rtc_sec_i = '0;
        key_xfer_i = 0; alm_we = 0; alm_wdata = '0; diag_we = 0; diag_wdata = '0;
        cfg_we = 0; cfg_en_i = '0; cfg_lotemp_i = 0; cfg_lock_i = 0;
        step(); step();
        // R1 reset state
        chk(alarm_o == 0 && log_o == 0 && diag_o == 0, "R1 reset regs", alarm_o | log_o | diag_o, 0);
        chk(!drs_req_o && !wipe_req_o && int_en_o == 0 && !int_lock_o && !lotemp_sel_o,
            "R1 reset outputs", {drs_req_o, wipe_req_o, int_lock_o, lotemp_sel_o}, 0);
        bat_rst = 1'b0;
        step();
        chk(diag_o == 32'h1, "R1 power flag", diag_o, 32'h1);

        // R9 configure unlocked
        en_cfg = 10'h1D7;
        cfg_we = 1; cfg_en_i = en_cfg; cfg_lotemp_i = 0; cfg_lock_i = 0;
        step(); cfg_we = 0;
        chk(int_en_o == en_cfg && !int_lock_o, "R9 load", {22'd0, int_en_o}, {22'd0, en_cfg});

        // R3 set wins over clear, then clear succeeds
        int_evt_i = 10'h001; step();
        chk(alarm_o == 32'h4, "R2 shield bit 2", alarm_o, 32'h4);
        alm_we = 1; alm_wdata = 32'h4; step();
        chk(alarm_o == 32'h4, "R3 clear ignored with live event", alarm_o, 32'h4);
        int_evt_i = '0; step(); alm_we = 0;
        chk(alarm_o == 0, "R3 clear", alarm_o, 0);

        // R2 disabled source (battery low, enable bit 3 is 0)
        int_evt_i = 10'h008; step(); int_evt_i = '0;
        chk(alarm_o == 0, "R2 disabled source ignored", alarm_o, 0);

        // R2 R3 R4 random traffic
        m_int = '0; m_ext = '0;
        for (int i = 0; i < 300; i++) begin
            int_evt_i = 10'($urandom & $urandom & $urandom);
            ext_det_i = 6'($urandom & $urandom);
            ext_en_i  = 6'($urandom);
            alm_we    = ($urandom % 3) == 0;
            alm_wdata = $urandom & 32'hFFFF_FFFC;
            for (int k = 0; k < 10; k++) clr_i[k] = alm_we & alm_wdata[src_pos(k)];
            clr_e = {6{alm_we}} & alm_wdata[21:16];
            m_int = (m_int & ~clr_i) | (int_evt_i & en_cfg);
            m_ext = (m_ext & ~clr_e) | (ext_det_i & ext_en_i);
            step();
            chk(alarm_o == exp_word(m_int, m_ext, 0, 0), "R2 R3 R4 random flags",
                alarm_o, exp_word(m_int, m_ext, 0, 0));
        end
        int_evt_i = '0; ext_det_i = '0; ext_en_i = '0;
        alm_we = 1; alm_wdata = 32'hFFFF_FFFC; step(); alm_we = 0; alm_wdata = '0;
        chk(alarm_o == 0, "R3 R4 clear all", alarm_o, 0);

        // R5 R6 destructive reset alone
        rtc_sec_i = 32'h1234_5678;
        alm_we = 1; alm_wdata = 32'h1; step(); alm_we = 0; alm_wdata = '0;
        chk(alarm_o == 32'h1 && !drs_req_o, "R5 trigger pending", alarm_o, 32'h1);
        step();
        chk(drs_req_o && alarm_o == 0, "R5 request pulse", {drs_req_o, alarm_o[30:0]}, 32'h8000_0000);
        chk(log_o == 32'h1234_5678, "R6 timestamp", log_o, 32'h1234_5678);
        rtc_sec_i = 32'hCAFE_0001;
        step();
        chk(!drs_req_o && log_o == 32'h1234_5678, "R5 R6 pulse ends, log held", log_o, 32'h1234_5678);

        // R7 key erase alone
        alm_we = 1; alm_wdata = 32'h2; step(); alm_we = 0; alm_wdata = '0;
        for (int j = 0; j < 4; j++) begin
            chk(wipe_req_o && alarm_o == 32'h2 && !drs_req_o, "R7 erase active",
                {wipe_req_o, alarm_o[30:0]}, 32'h8000_0002);
            step();
        end
        chk(!wipe_req_o && alarm_o == 0 && !drs_req_o, "R7 erase ends", alarm_o, 0);
        chk(log_o == 32'h1234_5678, "R7 no timestamp", log_o, 32'h1234_5678);

        // R8 both in one write
        rtc_sec_i = 32'h0BAD_F00D;
        alm_we = 1; alm_wdata = 32'h3; step(); alm_we = 0; alm_wdata = '0;
        for (int j = 0; j < 4; j++) begin
            chk(wipe_req_o && !drs_req_o && alarm_o == 32'h3, "R8 erase first",
                {wipe_req_o, drs_req_o, alarm_o[29:0]}, 32'h8000_0003);
            step();
        end
        chk(!wipe_req_o && !drs_req_o && alarm_o == 32'h1, "R8 gap cycle", alarm_o, 32'h1);
        step();
        chk(drs_req_o && log_o == 32'h0BAD_F00D, "R8 R6 reset after erase", log_o, 32'h0BAD_F00D);
        step();

        // R9 lock
        cfg_we = 1; cfg_en_i = 10'h3FF; cfg_lotemp_i = 1; cfg_lock_i = 1;
        step();
        cfg_en_i = 10'h000; cfg_lotemp_i = 0; cfg_lock_i = 0;
        chk(int_lock_o && lotemp_sel_o && int_en_o == 10'h3FF, "R9 locked load",
            {20'd0, int_lock_o, lotemp_sel_o, int_en_o}, {20'd0, 2'b11, 10'h3FF});
        step(); cfg_we = 0;
        chk(int_lock_o && lotemp_sel_o && int_en_o == 10'h3FF, "R9 write ignored when locked",
            {20'd0, int_lock_o, lotemp_sel_o, int_en_o}, {20'd0, 2'b11, 10'h3FF});

        // R10 diagnostic flags
        key_xfer_i = 1; step(); key_xfer_i = 0;
        chk(diag_o == 32'h101, "R10 key flag set", diag_o, 32'h101);
        diag_we = 1; diag_wdata = 32'hFFFF_FFFF; step(); diag_we = 0; diag_wdata = '0;
        chk(diag_o == 32'h100, "R10 power flag cleared, key flag kept", diag_o, 32'h100);
        step();
        chk(diag_o == 32'h100, "R10 power flag stays clear", diag_o, 32'h100);

        // R1 R10 battery reset clears all
        saved = log_o;
        bat_rst = 1; step();
        chk(diag_o == 0 && log_o == 0 && !int_lock_o && int_en_o == 0, "R1 R10 battery reset",
            diag_o | log_o, 0);
        bat_rst = 0; step();
        chk(diag_o == 32'h1, "R1 power flag after battery reset", diag_o, 32'h1);
        if (saved != 32'h0BAD_F00D) chk(0, "R6 log before reset", saved, 32'h0BAD_F00D);

        finish_run();
    end
endmodule